// File: doc/BRIEF.md
# Line-Repeating Double-Buffered Frame Buffer Scanner

This block walks a small stored picture out of a 16-bit-wide synchronous RAM in raster order, so that the picture fills a much taller display raster. A column counter moves along a stored line with each pixel enable. A line counter, behind a repeat divider, moves down the stored picture only after each stored line has been drawn on a fixed number of consecutive scan lines. The RAM is split into two halves by its top address bit. A bank-select input chooses which half is shown, so software can draw into one half while the other is on screen.

Each RAM word packs two pixels. The column counter's lowest bit does not go to the RAM address. It is delayed to match the one-cycle RAM read latency and then picks the low or high byte of the returned word. The pixel output is a valid-qualified stream with no ready input, because a raster cannot wait. The downstream side must take every pixel in the cycle `pix_valid` is high, and `pix_out` is zero in every other cycle. Sync and porch timing come from outside through the `line_start` and `frame_start` strobes.

The default geometry is 128 pixels by 32 stored lines per bank, with each line repeated 15 times (480 scan lines). Pixel enables past the end of a line, and lines past the end of the stored picture, produce blank (invalid) output.

Top module: `fb_scanner`

## Requirements
- R1: While `rst_n` is low and after its release, `ram_addr`, `pix_valid` and `pix_out` are all zero until the first strobe or pixel enable.
- R2: A `frame_start` clears the column, line and repeat counters, so in the next cycle `ram_addr[10:0]` is zero. It also ends any blanking of lines or columns.
- R3: `bank_sel` is captured only in a cycle with `frame_start` high. The captured value is `ram_addr[11]` and does not change at any other time.
- R4: `ram_addr` is `{bank, line[4:0], col[6:1]}`, where `col` is the index of the next pixel in the stored line and `line` is the stored line index.
- R5: Each accepted pixel enable advances `col` by one. A `line_start` without `frame_start` sets `col` to zero.
- R6: The stored line index advances by one on every 15th `line_start` after `frame_start`. Scan line n (n = 0 at `frame_start`) therefore shows stored line n/15.
- R7: One cycle after an accepted pixel enable, `pix_valid` is high and `pix_out` is `ram_rdata[7:0]` if that pixel's `col` was even, or `ram_rdata[15:8]` if it was odd. `ram_rdata` is the word the RAM returns one cycle after it was addressed.
- R8: A pixel enable is accepted only when both strobes are low. `frame_start` takes precedence over `line_start`, and `line_start` takes precedence over `pix_enable`. In any cycle after a cycle with no accepted enable, `pix_valid` is low and `pix_out` is zero.
- R9: After the 128th accepted pixel of a scan line, further pixel enables on that line give `pix_valid` low and leave `ram_addr` unchanged.
- R10: The `line_start` that follows the last repeat of the last stored line blanks the rest of the frame. From then until the next `frame_start`, `pix_valid` stays low and `ram_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel enable, one per displayed pixel slot |
| line_start | input | 1 | Strobe at the start of each scan line |
| frame_start | input | 1 | Strobe at the start of each frame (also begins scan line 0) |
| bank_sel | input | 1 | Requested display half, sampled at frame start |
| ram_rdata | input | 16 | Word from RAM, one cycle after its address |
| ram_addr | output | 12 | RAM word address: bank, stored line, word column |
| pix_valid | output | 1 | Pixel on `pix_out` is valid this cycle |
| pix_out | output | 8 | Selected pixel byte, zero when not valid |

## Verification
A wrong column or line count appears directly on `ram_addr` in the cycle after the enable or strobe that caused it. A wrong repeat divider only shows when a stored line boundary is crossed, at most 15 scan lines later. A byte-select latched one cycle early or late swaps neighbouring pixels, so `pix_out` disagrees with the expected byte on the next valid pixel. A RAM model whose words have distinct high and low bytes exposes this at once. Faults in the end-of-line or end-of-picture blanking show up as a stray `pix_valid` on the first enable past the limit. A bank sampled outside frame start flips `ram_addr[11]` within one cycle of a mid-frame `bank_sel` change.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  // Decoded control for one cycle, precedence already applied.
  typedef struct packed {
    logic frame;   // frame start wins over everything
    logic line;    // line start when no frame start
    logic pix;     // pixel enable when no strobe
  } fbs_ctl_t;

  function automatic fbs_ctl_t fbs_decode(input logic fs, input logic ls, input logic pe);
    fbs_ctl_t c;
    c.frame = fs;
    c.line  = ls & ~fs;
    c.pix   = pe & ~ls & ~fs;
    return c;
  endfunction

endpackage

// File: rtl/fbs_col_ctr.sv
module fbs_col_ctr #(
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  output logic [COL_W-1:0] col,
  output logic             col_done
);
  localparam logic [COL_W-1:0] COL_LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col      <= '0;
      col_done <= 1'b0;
    end else if (clear) begin
      col      <= '0;
      col_done <= 1'b0;
    end else if (adv) begin
      if (col == COL_LAST) col_done <= 1'b1;
      else                 col      <= col + 1'b1;
    end
  end
endmodule

// File: rtl/fbs_row_ctr.sv
module fbs_row_ctr #(
  parameter int ROW_W  = 5,
  parameter int REPEAT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [ROW_W-1:0] row,
  output logic             rows_done
);
  localparam int RPT_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;
  localparam logic [RPT_W-1:0] RPT_LAST = RPT_W'(REPEAT - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = '1;

  logic [RPT_W-1:0] rep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep       <= '0;
      row       <= '0;
      rows_done <= 1'b0;
    end else if (clear) begin
      rep       <= '0;
      row       <= '0;
      rows_done <= 1'b0;
    end else if (step && !rows_done) begin
      if (rep == RPT_LAST) begin
        rep <= '0;
        if (row == ROW_LAST) rows_done <= 1'b1;
        else                 row       <= row + 1'b1;
      end else begin
        rep <= rep + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbs_pix_sel.sv
module fbs_pix_sel #(
  parameter int PIX_W = 8,
  parameter int PPW   = 2,
  localparam int SEL_W  = (PPW > 1) ? $clog2(PPW) : 1,
  localparam int WORD_W = PIX_W * PPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] word,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_out
);
  logic [PIX_W-1:0] lane [PPW];
  logic [SEL_W-1:0] sel_q;

  for (genvar g = 0; g < PPW; g++) begin : g_lane
    assign lane[g] = word[g*PIX_W +: PIX_W];
  end

  // Align the byte select with the one-cycle RAM read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= acc;
      if (acc) sel_q <= sel;
    end
  end

  always_comb begin
    pix_out = '0;
    for (int i = 0; i < PPW; i++)
      if (pix_valid && sel_q == SEL_W'(i)) pix_out = lane[i];
  end
endmodule

// File: rtl/fb_scanner.sv
module fb_scanner #(
  parameter int COL_W  = 7,
  parameter int ROW_W  = 5,
  parameter int REPEAT = 15,
  parameter int PIX_W  = 8,
  parameter int PPW    = 2,
  localparam int SEL_W  = (PPW > 1) ? $clog2(PPW) : 1,
  localparam int WORD_W = PIX_W * PPW,
  localparam int ADDR_W = 1 + ROW_W + COL_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              bank_sel,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_out
);
  import fbs_pkg::*;

  fbs_ctl_t         ctl;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             col_done, rows_done, acc, bank_q;

  assign ctl = fbs_decode(frame_start, line_start, pix_en);
  assign acc = ctl.pix & ~col_done & ~rows_done;

  always_ff @(posedge clk) begin
    if (!rst_n)         bank_q <= 1'b0;
    else if (ctl.frame) bank_q <= bank_sel;
  end

  fbs_col_ctr #(.COL_W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n),
    .clear(ctl.frame | ctl.line), .adv(acc),
    .col(col), .col_done(col_done)
  );

  fbs_row_ctr #(.ROW_W(ROW_W), .REPEAT(REPEAT)) u_row (
    .clk(clk), .rst_n(rst_n),
    .clear(ctl.frame), .step(ctl.line),
    .row(row), .rows_done(rows_done)
  );

  assign ram_addr = {bank_q, row, col[COL_W-1:SEL_W]};

  fbs_pix_sel #(.PIX_W(PIX_W), .PPW(PPW)) u_sel (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .sel(col[SEL_W-1:0]), .word(ram_rdata),
    .pix_valid(pix_valid), .pix_out(pix_out)
  );
endmodule

// File: rtl/fb_scanner_chk.sv
module fb_scanner_chk #(
  parameter int ADDR_W = 12,
  parameter int WCOL_W = 6,
  parameter int PIX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic              line_start,
  input logic              frame_start,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              pix_valid,
  input logic [PIX_W-1:0]  pix_out
);
  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(ram_addr[ADDR_W-1]));
  // R2
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ram_addr[ADDR_W-2:0] == '0);
  // R5
  line_col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start) |=> ram_addr[WCOL_W-1:0] == '0);
  // R8
  no_enable_no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> !pix_valid);
  // R8
  strobe_blocks_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start || frame_start) |=> !pix_valid);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix_out == '0);
endmodule

bind fb_scanner fb_scanner_chk #(
  .ADDR_W(ADDR_W), .WCOL_W(COL_W - SEL_W), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
  .frame_start(frame_start), .ram_addr(ram_addr),
  .pix_valid(pix_valid), .pix_out(pix_out)
);

// File: tb/sim_fb_scanner.sv
module sim_fb_scanner;
  localparam int NCOL = 128, NROW = 32, RPT = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 0, line_start = 0, frame_start = 0, bank_sel = 0;
  logic [15:0] ram_rdata = '0;
  logic [11:0] ram_addr;
  logic        pix_valid;
  logic [7:0]  pix_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fb_scanner #(.COL_W(7), .ROW_W(5), .REPEAT(RPT), .PIX_W(8), .PPW(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
    .frame_start(frame_start), .bank_sel(bank_sel), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .pix_valid(pix_valid), .pix_out(pix_out)
  );

  function automatic logic [15:0] fill(input logic [11:0] a);
    return (16'(a) * 16'd40503) ^ 16'h5a3c;
  endfunction

  // Synchronous RAM model, one-cycle read latency.
  always @(posedge clk) ram_rdata <= fill(ram_addr);

  // Bench model of the scan state.
  int m_col = 0, m_row = 0, m_rep = 0;
  bit m_bank = 0, m_cd = 0, m_rd = 0, e_valid = 0;
  logic [7:0] e_pix = '0;

  function automatic logic [11:0] m_addr();
    return {m_bank, 5'(m_row), 6'(m_col >> 1)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input bit pe, input bit ls, input bit fs, input bit bs);
    logic [15:0] w;
    e_valid = 0;
    e_pix = '0;
    if (fs) begin
      m_col = 0; m_row = 0; m_rep = 0; m_bank = bs; m_cd = 0; m_rd = 0;
    end else if (ls) begin
      m_col = 0; m_cd = 0;
      if (!m_rd) begin
        if (m_rep == RPT - 1) begin
          m_rep = 0;
          if (m_row == NROW - 1) m_rd = 1; else m_row++;
        end else m_rep++;
      end
    end else if (pe && !m_cd && !m_rd) begin
      w = fill(m_addr());
      e_valid = 1;
      e_pix = m_col[0] ? w[15:8] : w[7:0];
      if (m_col == NCOL - 1) m_cd = 1; else m_col++;
    end
  endtask

  // One clock: drive at negedge, model at posedge, check at next negedge.
  task automatic cyc(input bit pe, input bit ls, input bit fs, input bit bs);
    pix_en = pe; line_start = ls; frame_start = fs; bank_sel = bs;
    @(posedge clk);
    model_step(pe, ls, fs, bs);
    @(negedge clk);
    chk(ram_addr == m_addr(), "R4 address", ram_addr, m_addr());
    chk(pix_valid == e_valid, "R8 valid", pix_valid, e_valid);
    if (e_valid) chk(pix_out == e_pix, "R7 byte select", pix_out, e_pix);
    else         chk(pix_out == 8'h00, "R8 idle zero", pix_out, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ram_addr == 12'h000, "R1 reset addr", ram_addr, 0);
    chk(pix_valid == 1'b0, "R1 reset valid", pix_valid, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    chk(ram_addr == 12'h000 && pix_out == 8'h00, "R1 after release", ram_addr, 0);

    // R2: frame start with bank 1
    cyc(1, 0, 0, 0);
    cyc(1, 0, 1, 1);
    chk(ram_addr == 12'h800, "R2 frame clear", ram_addr, 12'h800);
    // R5: five pixels put the word column at 2
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 1);
    chk(ram_addr[5:0] == 6'd2, "R5 column advance", ram_addr[5:0], 2);
    // R3: bank change mid-frame has no effect
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    chk(ram_addr[11] == 1'b1, "R3 bank held", ram_addr[11], 1);
    // R8: strobe and enable together, line start wins
    cyc(1, 1, 0, 0);
    chk(pix_valid == 1'b0 && ram_addr[5:0] == 0, "R5 line clear", ram_addr[5:0], 0);

    // Full directed frame on bank 0
    cyc(0, 0, 1, 0);
    for (int ln = 0; ln <= NROW * RPT; ln++) begin
      if (ln > 0) cyc(0, 1, 0, 0);
      for (int p = 0; p < NCOL + 2; p++) cyc(1, 0, 0, 0);
      if (ln == 0) begin
        // R9: enables past the line end are blank, address held
        chk(pix_valid == 1'b0, "R9 past line end", pix_valid, 0);
        chk(ram_addr[5:0] == 6'd63, "R9 address held", ram_addr[5:0], 63);
      end
      if (ln < NROW * RPT)
        chk(int'(ram_addr[10:6]) == ln / RPT, "R6 line repeat", ram_addr[10:6], ln / RPT);
      else begin
        chk(pix_valid == 1'b0, "R10 picture end blank", pix_valid, 0);
        chk(ram_addr[10:6] == 5'd31, "R10 address held", ram_addr[10:6], 31);
      end
    end
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0);
    chk(pix_valid == 1'b0, "R10 stays blank", pix_valid, 0);
    cyc(0, 0, 1, 1);
    cyc(1, 0, 0, 1);
    chk(pix_valid == 1'b1, "R2 frame restarts", pix_valid, 1);

    // Constrained random phase
    begin
      bit bs = 1;
      for (int i = 0; i < 30000; i++) begin
        bit fs = ($urandom % 3000) == 0;
        bit ls = ($urandom % 140) == 0;
        bit pe = ($urandom % 10) != 0;
        if (($urandom % 50) == 0) bs = ~bs;
        cyc(pe, ls, fs, bs);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule